// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the stream of column addresses that a synchronous DRAM-style memory needs, one address per clock. A request carries a starting column, a 3-bit length code, an ordering bit and the access direction. The block also takes a write-override bit that shrinks writes to a single location. After a request is accepted, the block presents one column per cycle with a valid flag, and it marks the final beat with a last flag.

Sequential bursts step upward and wrap inside the aligned block of the burst length. Interleaved bursts flip the low address bits following the beat count. A full-page burst walks the whole row, wrapping from the top column to column zero, until a stop input ends it. Any burst can be ended early by the stop input. A request with a reserved code starts nothing and raises an error flag for one cycle. Row and bank selection, command issue and data timing belong to the surrounding controller.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and afterwards until the first request, `valid_o`, `last_o` and `err_o` are all 0.
- R2: Length codes 0, 1, 2 and 3 produce bursts of 1, 2, 4 and 8 beats. `valid_o` is high for exactly that many consecutive cycles, and `last_o` is high only on the final one.
- R3: With `ileave_i` = 0 (sequential), beat k carries the start column with its low log2(L) bits replaced by (start + k) mod L. The bits above them stay fixed, so the burst wraps inside its aligned block.
- R4: With `ileave_i` = 1 (interleaved), beat k carries the start column with its low log2(L) bits XORed with k.
- R5: Length code 7 with `ileave_i` = 0 gives a full-page burst. Beat k carries (start + k) mod 512, so the burst wraps from column 511 to column 0, and `last_o` stays low until the burst is stopped.
- R6: `stop_i` high during a valid beat makes that beat the final one. `last_o` rises in the same cycle and `valid_o` is low in the next.
- R7: When `is_write_i` = 1 and `single_wr_i` = 1, an accepted burst has exactly one beat for any non-reserved code. Reads (`is_write_i` = 0) keep the programmed length whatever `single_wr_i` is.
- R8: Length codes 4, 5 and 6 with either ordering, and code 7 with `ileave_i` = 1, are reserved. Such a request starts no burst, and `err_o` is high for exactly the one cycle after it.
- R9: `start_i` is ignored while a burst is running, including on its last beat. The running burst's addresses and length are unchanged.
- R10: An accepted request shows its first beat, carrying `start_col_i`, in the cycle after `start_i` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a burst this cycle |
| start_col_i | input | COL_W | Starting column of the request |
| len_code_i | input | 3 | Length code: 0..3 give 1/2/4/8, 7 is full page, others reserved |
| ileave_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| is_write_i | input | 1 | Request is a write |
| single_wr_i | input | 1 | Force writes to a single location |
| stop_i | input | 1 | End the running burst after the current beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Previous cycle held a rejected reserved request |

## Verification
The hardest case to reach from the ports is the full-page wrap from column 511 to column 0. It occurs only deep into a full-page burst unless the start column sits near the top of the row. The stimulus starts one full-page burst three columns below the top, so the wrap comes within a few beats. It then runs a second full-page burst for more than 512 beats before stopping it, so the count passes the whole row and comes back to its starting column. A stop that lands on a burst's natural last beat and a new request held high across a final beat are also driven on purpose, since both meet the end-of-burst logic in the same cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   // The 3-bit length code can express at most eight beats in fixed-length mode.
   localparam int unsigned LOG_MAX = 3;
   localparam int unsigned LG_W    = $clog2(LOG_MAX + 1);

   typedef struct packed {
      logic            rsvd;  // code not usable with this ordering
      logic            full;  // run until stopped
      logic [LG_W-1:0] lg;    // log2 of the burst length
   } len_dec_t;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
   import bcg_pkg::*;
(
   input  logic [2:0] code_i,
   input  logic       ileave_i,
   input  logic       force_one_i,
   output len_dec_t   dec_o
);
   logic code_full;

   assign code_full = (code_i == 3'b111);

   always_comb begin
      dec_o.rsvd = code_i[2] & ~(code_full & ~ileave_i);
      dec_o.full = code_full & ~ileave_i & ~force_one_i;
      dec_o.lg   = force_one_i ? '0 : LG_W'(code_i[1:0]);
   end
endmodule

// File: rtl/bcg_addr_step.sv
module bcg_addr_step
   import bcg_pkg::*;
#(
   parameter int unsigned COL_W = 9
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  logic [LG_W-1:0]  lg_i,
   input  logic             ileave_i,
   input  logic             full_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] sum;

   // The low bits of a plain sum never see carries from above, so the same
   // adder serves both the wrapping window and the full-row walk.
   assign sum = base_i + cnt_i;

   generate
      for (genvar i = 0; i < COL_W; i++) begin : g_bit
         if (i < LOG_MAX) begin : g_win
            logic in_win;
            assign in_win   = (i < int'(lg_i));
            assign col_o[i] = full_i ? sum[i]
                            : in_win ? (ileave_i ? (base_i[i] ^ cnt_i[i]) : sum[i])
                            : base_i[i];
         end else begin : g_hi
            assign col_o[i] = full_i ? sum[i] : base_i[i];
         end
      end
   endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int unsigned COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_code_i,
   input  logic             ileave_i,
   input  logic             is_write_i,
   input  logic             single_wr_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             err_o
);
   initial begin
      assert (COL_W > LOG_MAX)
         else $error("COL_W must exceed the widest burst window");
   end

   len_dec_t         dec;
   logic             busy_q, ilv_q, full_q, err_q;
   logic [COL_W-1:0] base_q, cnt_q, end_cnt;
   logic [LG_W-1:0]  lg_q;
   logic             accept, at_end;

   bcg_len_decode u_dec (
      .code_i      (len_code_i),
      .ileave_i    (ileave_i),
      .force_one_i (is_write_i & single_wr_i),
      .dec_o       (dec)
   );

   bcg_addr_step #(.COL_W(COL_W)) u_addr (
      .base_i   (base_q),
      .cnt_i    (cnt_q),
      .lg_i     (lg_q),
      .ileave_i (ilv_q),
      .full_i   (full_q),
      .col_o    (col_o)
   );

   assign accept  = start_i & ~busy_q & ~dec.rsvd;
   assign end_cnt = COL_W'((1 << lg_q) - 1);
   assign at_end  = ~full_q & (cnt_q == end_cnt);
   assign last_o  = busy_q & (at_end | stop_i);
   assign valid_o = busy_q;
   assign err_o   = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ilv_q  <= 1'b0;
         full_q <= 1'b0;
         err_q  <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
         lg_q   <= '0;
      end else begin
         err_q <= start_i & ~busy_q & dec.rsvd;
         if (accept) begin
            busy_q <= 1'b1;
            base_q <= start_col_i;
            cnt_q  <= '0;
            lg_q   <= dec.lg;
            ilv_q  <= ileave_i;
            full_q <= dec.full;
         end else if (busy_q) begin
            if (last_o) busy_q <= 1'b0;
            else        cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   // R10: first beat carries the requested column one cycle later
   p_first_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (valid_o && col_o == $past(start_col_i)));

   // R8: a reserved request flags an error and starts nothing
   p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !valid_o && dec.rsvd) |=> (err_o && !valid_o));

   // R6: after the final beat the block is idle
   p_last_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> !valid_o);

   // R2: beats are contiguous until the final one
   p_no_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o) |=> valid_o);

   // R7: forced single write ends on its first beat
   p_single_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_write_i && single_wr_i) |=> last_o);

   // R3: outside full-page mode the bits above the window never move
   p_window_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !full_q && $past(valid_o && !last_o))
         |-> (col_o[COL_W-1:LOG_MAX] == $past(col_o[COL_W-1:LOG_MAX])));
endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
   localparam int COLS = 512;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [8:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       ileave_i = 1'b0;
   logic       is_write_i = 1'b0;
   logic       single_wr_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [8:0] col_o;
   logic       valid_o, last_o, err_o;

   always #4 clk = ~clk;

   burst_col_gen #(.COL_W(9)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .ileave_i(ileave_i), .is_write_i(is_write_i),
      .single_wr_i(single_wr_i), .stop_i(stop_i), .col_o(col_o),
      .valid_o(valid_o), .last_o(last_o), .err_o(err_o));

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // Behavioural reference state
   bit m_busy = 0, m_full = 0, m_ilv = 0, m_err = 0;
   int m_base = 0, m_cnt = 0, m_len = 1;

   function automatic bit model_last();
      return m_busy && ((!m_full && m_cnt == m_len - 1) || stop_i);
   endfunction

   function automatic int model_col();
      if (m_full)     return (m_base + m_cnt) % COLS;
      else if (m_ilv) return m_base ^ m_cnt;
      else            return (m_base & ~(m_len - 1)) | ((m_base + m_cnt) % m_len);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_full = 0; m_ilv = 0; m_err = 0;
         m_base = 0; m_cnt = 0; m_len = 1;
      end else begin
         bit was_busy, ends;
         was_busy = m_busy;
         ends = model_last();
         m_err = 0;
         if (was_busy) begin
            if (ends) m_busy = 0;
            else      m_cnt = m_cnt + 1;
         end else if (start_i) begin
            if (len_code_i >= 4 && !(len_code_i == 7 && !ileave_i)) begin
               m_err = 1;
            end else begin
               m_busy = 1;
               m_cnt  = 0;
               m_base = int'(start_col_i);
               m_ilv  = ileave_i;
               if (is_write_i && single_wr_i) begin
                  m_full = 0; m_len = 1;
               end else if (len_code_i == 7) begin
                  m_full = 1; m_len = 1;
               end else begin
                  m_full = 0; m_len = 1 << len_code_i;
               end
            end
         end
      end
   end

   task automatic compare();
      bit ev, el, ee, ok;
      int ec;
      ev = m_busy; el = model_last(); ee = m_err; ec = model_col();
      ok = (valid_o == ev) && (last_o == el) && (err_o == ee) &&
           (!ev || int'(col_o) == ec);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s t=%0t actual v=%0b l=%0b e=%0b col=%03h expected v=%0b l=%0b e=%0b col=%03h",
                  cur_req, $time, valid_o, last_o, err_o, col_o, ev, el, ee, ec[8:0]);
      end
   endtask

   // Inputs change at the falling edge; outputs are compared just before the rising edge.
   task automatic cycle();
      #3;
      compare();
      @(negedge clk);
   endtask

   task automatic burst(input int col, input int code, input bit ilv, input bit wr,
                        input bit sw, input int run, input int stop_at, input string req);
      cur_req     = req;
      start_i     = 1'b1;
      start_col_i = 9'(col);
      len_code_i  = 3'(code);
      ileave_i    = ilv;
      is_write_i  = wr;
      single_wr_i = sw;
      cycle();
      start_i = 1'b0;
      for (int k = 0; k < run; k++) begin
         stop_i = (k == stop_at);
         cycle();
      end
      stop_i = 1'b0;
      cycle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog req=all actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      cur_req = "R1";
      repeat (3) cycle();          // reset held
      rst_n = 1'b1;
      repeat (3) cycle();          // idle after reset

      // R2 lengths, R10 first beat
      burst(9'h010, 0, 0, 0, 0, 3, -1, "R2");
      burst(9'h045, 1, 0, 0, 0, 4, -1, "R2");
      burst(9'h045, 2, 0, 0, 0, 6, -1, "R2");
      burst(9'h045, 3, 0, 0, 0, 10, -1, "R2");
      burst(9'h1C3, 2, 0, 0, 0, 6, -1, "R10");

      // R3 sequential wrap inside the aligned block
      burst(9'h1F5, 3, 0, 0, 0, 10, -1, "R3");
      burst(9'h0AE, 2, 0, 0, 0, 6, -1, "R3");
      burst(9'h0FF, 1, 0, 0, 0, 4, -1, "R3");

      // R4 interleaved ordering
      burst(9'h0A3, 3, 1, 0, 0, 10, -1, "R4");
      burst(9'h15E, 2, 1, 0, 0, 6, -1, "R4");
      burst(9'h101, 1, 1, 0, 0, 4, -1, "R4");

      // R5 full page: early wrap, then a run past a whole row
      burst(9'h1FD, 7, 0, 0, 0, 8, 5, "R5");
      burst(9'h100, 7, 0, 0, 0, 530, 519, "R5");

      // R6 early stop, and stop on the natural last beat
      burst(9'h022, 3, 0, 0, 0, 10, 2, "R6");
      burst(9'h030, 2, 0, 0, 0, 6, 3, "R6");
      burst(9'h0C7, 3, 1, 0, 0, 10, 0, "R6");

      // R7 write override
      burst(9'h033, 3, 0, 1, 1, 4, -1, "R7");
      burst(9'h033, 7, 0, 1, 1, 4, -1, "R7");
      burst(9'h033, 3, 0, 0, 1, 10, -1, "R7");
      burst(9'h033, 2, 1, 1, 0, 6, -1, "R7");

      // R8 reserved codes
      burst(9'h011, 4, 0, 0, 0, 2, -1, "R8");
      burst(9'h011, 5, 1, 0, 0, 2, -1, "R8");
      burst(9'h011, 6, 0, 1, 1, 2, -1, "R8");
      burst(9'h011, 7, 1, 0, 0, 2, -1, "R8");

      // R9 new requests while a burst runs, including on its last beat
      cur_req = "R9";
      start_i = 1'b1; start_col_i = 9'h064; len_code_i = 3'd2;
      ileave_i = 1'b0; is_write_i = 1'b0; single_wr_i = 1'b0;
      cycle();
      start_i = 1'b0;
      cycle();
      start_i = 1'b1; start_col_i = 9'h1FF; len_code_i = 3'd3; ileave_i = 1'b1;
      cycle();
      start_i = 1'b0;
      cycle();
      start_i = 1'b1; start_col_i = 9'h0F0; len_code_i = 3'd5;
      cycle();                      // last beat of the running burst
      start_i = 1'b0;
      repeat (4) cycle();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule